// File: doc/BRIEF.md
# Five-Port Mesh Router with Input Queues

This block switches single-flit packets between the four neighbours of a node in a two-dimensional mesh and the node's own processor. Every flit carries two signed hop counts, one per axis, that say how far the packet still has to travel. Each of the five inputs owns a small queue and its own route decision. Each of the five outputs owns a round-robin arbiter that chooses among the queue heads that want it. The chosen flit crosses a crossbar to that output.

Routing is dimension-ordered. The horizontal count is worked to zero first, then the vertical one, and a packet with both counts at zero leaves on the processor port. On the way out, the router moves the count for the axis being travelled one step closer to zero, so the next router sees the distance that is left. Every port uses a valid/ready handshake. Because each input has one queue, a head flit that cannot leave holds back every flit queued behind it.

Top module: `mesh_router`

## Requirements
- R1: A head flit whose horizontal count dx (bits [DATA_W+OFF_W-1:DATA_W], two's complement) is positive leaves on output 3 (east) with dx lowered by one. A negative dx sends it to output 4 (west) with dx raised by one. In both cases the vertical count is not changed.
- R2: With dx equal to zero, a positive vertical count dy (bits [FW-1:DATA_W+OFF_W]) sends the flit to output 1 (north) with dy lowered by one. A negative dy sends it to output 2 (south) with dy raised by one.
- R3: With both counts at zero the flit leaves on output 0 (processor) unchanged. The payload, bits [DATA_W-1:0], is never modified on any output.
- R4: Port index i occupies bits [i*FW +: FW] of the flit buses. A flit accepted at a clock edge into an empty queue, whose output is free, is presented on its output directly after that edge.
- R5: When several inputs want one output, the inputs are served in round-robin order. The search starts just after the last input that completed a transfer on that output (input 0 after reset), and each accepted transfer serves exactly one input.
- R6: A head flit whose output is not ready blocks the flits behind it in the same queue, even when their own outputs are free.
- R7: Each input queue holds 4 flits in arrival order. in_ready is low while a queue is full, and a flit offered then is not stored.
- R8: A flit leaves its queue only on a cycle with out_valid and out_ready both high. While out_ready is low, out_valid and out_flit on that port stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 5 | Flit offered on each input port |
| in_ready | output | 5 | Input queue can take a flit |
| in_flit | input | 5*FW | Input flits, port i at [i*FW +: FW] |
| out_valid | output | 5 | Flit presented on each output port |
| out_ready | input | 5 | Neighbour takes the presented flit |
| out_flit | output | 5*FW | Output flits, port i at [i*FW +: FW] |

## Verification
Two things can happen in the same cycle: an output arbitrates between two queue heads, and a different output carries an unrelated flit. The bench queues two flits for the east output on separate inputs, together with one northbound flit, and then opens every output for a single edge. After that edge the northbound flit must be gone, the east output must still hold exactly the loser of the arbitration, and the loser must leave on the next edge. Output stability under back-pressure is judged both by bench checks held over several cycles and by a clocked property on every output.

// File: rtl/mesh_router.sv
module mesh_router #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4,
  parameter int DEPTH  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [4:0]                    in_valid,
  output logic [4:0]                    in_ready,
  input  logic [5*(DATA_W+2*OFF_W)-1:0] in_flit,
  output logic [4:0]                    out_valid,
  input  logic [4:0]                    out_ready,
  output logic [5*(DATA_W+2*OFF_W)-1:0] out_flit
);
  localparam int NP = 5;
  localparam int FW = DATA_W + 2*OFF_W;
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [2:0] P_LOC = 3'd0, P_N = 3'd1, P_S = 3'd2, P_E = 3'd3, P_W = 3'd4;
  localparam logic signed [OFF_W-1:0] ONE = OFF_W'(1);

  function automatic logic [2:0] route_of(input logic signed [OFF_W-1:0] dx,
                                          input logic signed [OFF_W-1:0] dy);
    if (dx > 0)      return P_E;
    else if (dx < 0) return P_W;
    else if (dy > 0) return P_N;
    else if (dy < 0) return P_S;
    else             return P_LOC;
  endfunction

  function automatic logic [FW-1:0] step(input logic [FW-1:0] f);
    logic signed [OFF_W-1:0] dx, dy;
    dx = f[DATA_W +: OFF_W];
    dy = f[DATA_W+OFF_W +: OFF_W];
    case (route_of(dx, dy))
      P_E:     dx = dx - ONE;
      P_W:     dx = dx + ONE;
      P_N:     dy = dy - ONE;
      P_S:     dy = dy + ONE;
      default: ;
    endcase
    return {dy, dx, f[DATA_W-1:0]};
  endfunction

  function automatic logic [2:0] rr_pick(input logic [2:0] start, input logic [NP-1:0] r);
    logic [2:0] w;
    int idx;
    w = start;
    for (int k = NP-1; k >= 0; k--) begin
      idx = int'(start) + k;
      if (idx >= NP) idx = idx - NP;
      if (r[idx]) w = 3'(idx);
    end
    return w;
  endfunction

  logic [FW-1:0]      head [NP];
  logic [FW-1:0]      fwd  [NP];
  logic [2:0]         rt   [NP];
  logic [2:0]         win  [NP];
  logic [NP-1:0]      hv;
  logic [NP-1:0]      deq;
  logic [NP*CW-1:0]   occ_flat;

  for (genvar i = 0; i < NP; i++) begin : g_in
    logic [FW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          push;

    assign in_ready[i] = cnt < CW'(DEPTH);
    assign push        = in_valid[i] && in_ready[i];
    assign hv[i]       = cnt != '0;
    assign head[i]     = mem[rp];
    assign rt[i]       = route_of(head[i][DATA_W +: OFF_W], head[i][DATA_W+OFF_W +: OFF_W]);
    assign fwd[i]      = step(head[i]);
    assign deq[i]      = hv[i] && out_ready[rt[i]] && (win[rt[i]] == 3'(i));
    assign occ_flat[i*CW +: CW] = cnt;

    always_ff @(posedge clk) begin
      if (push) mem[wp] <= in_flit[i*FW +: FW];
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        wp  <= '0;
        rp  <= '0;
        cnt <= '0;
      end else begin
        if (push)   wp <= (wp == PW'(DEPTH-1)) ? '0 : wp + 1'b1;
        if (deq[i]) rp <= (rp == PW'(DEPTH-1)) ? '0 : rp + 1'b1;
        cnt <= cnt + CW'(push) - CW'(deq[i]);
      end
    end
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [NP-1:0] req;
    logic [2:0]    ptr;

    for (genvar i = 0; i < NP; i++) begin : g_req
      assign req[i] = hv[i] && (rt[i] == 3'(o));
    end

    assign win[o]               = rr_pick(ptr, req);
    assign out_valid[o]         = |req;
    assign out_flit[o*FW +: FW] = fwd[win[o]];

    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr <= '0;
      else if (out_valid[o] && out_ready[o])
        ptr <= (win[o] == 3'(NP-1)) ? 3'd0 : win[o] + 3'd1;
      else if (out_valid[o])
        ptr <= win[o];
    end
  end
endmodule

module mesh_router_chk #(
  parameter int DATA_W = 8,
  parameter int OFF_W  = 4,
  parameter int DEPTH  = 4
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [4:0]                    out_valid,
  input logic [4:0]                    out_ready,
  input logic [5*(DATA_W+2*OFF_W)-1:0] out_flit,
  input logic [4:0]                    deq,
  input logic [5*$clog2(DEPTH+1)-1:0]  occ_flat
);
  localparam int FW = DATA_W + 2*OFF_W;
  localparam int CW = $clog2(DEPTH+1);

  logic signed [OFF_W-1:0] dxo [5];
  logic signed [OFF_W-1:0] dyo [5];
  for (genvar p = 0; p < 5; p++) begin : g_fld
    assign dxo[p] = out_flit[p*FW+DATA_W +: OFF_W];
    assign dyo[p] = out_flit[p*FW+DATA_W+OFF_W +: OFF_W];
  end

  assert_local_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[0] |-> (dxo[0] == 0 && dyo[0] == 0));
  assert_north_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[1] |-> (dxo[1] == 0 && dyo[1] >= 0));
  assert_south_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[2] |-> (dxo[2] == 0 && dyo[2] <= 0));
  assert_east_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[3] |-> (dxo[3] >= 0));
  assert_west_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid[4] |-> (dxo[4] <= 0));
  assert_one_per_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(deq) == $countones(out_valid & out_ready));

  for (genvar o = 0; o < 5; o++) begin : g_hold
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid[o] && !out_ready[o]) |=> (out_valid[o] && $stable(out_flit[o*FW +: FW])));
  end

  for (genvar i = 0; i < 5; i++) begin : g_occ
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      occ_flat[i*CW +: CW] <= CW'(DEPTH));
  end
endmodule

bind mesh_router mesh_router_chk #(.DATA_W(DATA_W), .OFF_W(OFF_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
  .out_flit(out_flit), .deq(deq), .occ_flat(occ_flat)
);

// File: tb/sim_mesh_router.sv
module sim_mesh_router;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 8, OFF_W = 4, FW = DATA_W + 2*OFF_W;

  logic              clk = 0, rst_n = 0;
  logic [4:0]        in_valid = '0, in_ready, out_valid, out_ready = '0;
  logic [5*FW-1:0]   in_flit = '0, out_flit;
  int n_tests = 0, n_fail = 0;

  mesh_router #(.DATA_W(DATA_W), .OFF_W(OFF_W), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_flit(in_flit), .out_valid(out_valid), .out_ready(out_ready), .out_flit(out_flit));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [FW-1:0] mk(input int dy, input int dx, input int d);
    return {OFF_W'(dy), OFF_W'(dx), DATA_W'(d)};
  endfunction

  function automatic int exp_port(input int dx, input int dy);
    if (dx > 0) return 3;
    if (dx < 0) return 4;
    if (dy > 0) return 1;
    if (dy < 0) return 2;
    return 0;
  endfunction

  function automatic logic [FW-1:0] exp_flit(input int dx, input int dy, input int d);
    if (dx > 0) return mk(dy, dx-1, d);
    if (dx < 0) return mk(dy, dx+1, d);
    if (dy > 0) return mk(dy-1, 0, d);
    if (dy < 0) return mk(dy+1, 0, d);
    return mk(0, 0, d);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    in_valid = '0;
    out_ready = '0;
    rst_n = 0;
    tick();
    tick();
    rst_n = 1;
  endtask

  task automatic push(input int p, input logic [FW-1:0] f);
    while (!in_ready[p]) tick();
    in_flit[p*FW +: FW] = f;
    in_valid[p] = 1'b1;
    tick();
    in_valid[p] = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R4", "out_valid after reset", 32'(out_valid), 32'h0);
    chk("R7", "in_ready after reset", 32'(in_ready), 32'h1f);
  endtask

  task automatic t_route_one(input int src, input int dx, input int dy, input int d);
    int p;
    p = exp_port(dx, dy);
    push(src, mk(dy, dx, d));
    chk(p == 0 ? "R3" : (p >= 3 ? "R1" : "R2"), "route port", 32'(out_valid), 32'(1 << p));
    chk("R4", "forwarded flit", 32'(out_flit[p*FW +: FW]), 32'(exp_flit(dx, dy, d)));
    tick();
    chk("R8", "flit gone after handshake", 32'(out_valid), 32'h0);
  endtask

  task automatic t_routes();
    do_reset();
    out_ready = 5'h1f;
    t_route_one(0, 3, -2, 8'h11);
    t_route_one(1, -1, 5, 8'h22);
    t_route_one(2, 0, 4, 8'h33);
    t_route_one(3, 0, -3, 8'h44);
    t_route_one(4, 0, 0, 8'h55);
    t_route_one(0, -8, 0, 8'h66);
    t_route_one(1, 7, 7, 8'h77);
    t_route_one(3, 0, 1, 8'h88);
  endtask

  task automatic t_hol();
    do_reset();
    out_ready = 5'h1f & ~5'h08;
    push(0, mk(0, 2, 8'hA1));
    push(0, mk(1, 0, 8'hB2));
    for (int k = 0; k < 3; k++) begin
      chk("R6", "north held behind blocked head", 32'(out_valid[1]), 32'h0);
      chk("R8", "east head held", 32'(out_flit[3*FW +: FW]), 32'(mk(0, 1, 8'hA1)));
      tick();
    end
    out_ready[3] = 1'b1;
    tick();
    chk("R6", "east drained", 32'(out_valid[3]), 32'h0);
    chk("R6", "north released", 32'(out_valid[1]), 32'h1);
    chk("R2", "north flit", 32'(out_flit[1*FW +: FW]), 32'(mk(0, 0, 8'hB2)));
    tick();
    chk("R8", "all drained", 32'(out_valid), 32'h0);
  endtask

  task automatic t_full();
    do_reset();
    for (int k = 0; k < 4; k++) push(2, mk(0, 0, 8'h10 + k));
    chk("R7", "in_ready low when full", 32'(in_ready[2]), 32'h0);
    chk("R8", "head presented while stalled", 32'(out_flit[0 +: FW]), 32'(mk(0, 0, 8'h10)));
    in_flit[2*FW +: FW] = mk(0, 0, 8'h99);
    in_valid[2] = 1'b1;
    tick();
    in_valid[2] = 1'b0;
    chk("R8", "head unchanged with ready low", 32'(out_flit[0 +: FW]), 32'(mk(0, 0, 8'h10)));
    out_ready[0] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R7", "drain order valid", 32'(out_valid[0]), 32'h1);
      chk("R7", "drain order flit", 32'(out_flit[0 +: FW]), 32'(mk(0, 0, 8'h10 + k)));
      tick();
    end
    chk("R7", "offered flit while full was dropped", 32'(out_valid[0]), 32'h0);
  endtask

  task automatic t_rr();
    do_reset();
    for (int i = 1; i < 5; i++)
      for (int n = 0; n < 2; n++) push(i, mk(0, 0, 16*i + n));
    out_ready[0] = 1'b1;
    for (int n = 0; n < 2; n++)
      for (int i = 1; i < 5; i++) begin
        chk("R5", "round-robin order", 32'(out_flit[0 +: FW]), 32'(mk(0, 0, 16*i + n)));
        tick();
      end
    chk("R5", "all served", 32'(out_valid[0]), 32'h0);
  endtask

  task automatic t_parallel();
    do_reset();
    push(0, mk(0, 1, 8'hC0));
    push(4, mk(0, 2, 8'hC4));
    push(2, mk(2, 0, 8'hC2));
    chk("R5", "east and north both offered", 32'(out_valid), 32'h0a);
    out_ready = 5'h1f;
    tick();
    out_ready = 5'h00;
    chk("R5", "north sent alongside arbitration", 32'(out_valid[1]), 32'h0);
    chk("R5", "east loser still valid", 32'(out_valid[3]), 32'h1);
    chk("R1", "east loser flit", 32'(out_flit[3*FW +: FW]), 32'(mk(0, 1, 8'hC4)));
    out_ready[3] = 1'b1;
    tick();
    chk("R5", "loser served next", 32'(out_valid), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_routes();
    t_hol();
    t_full();
    t_rr();
    t_parallel();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule